// File: doc/BRIEF.md
# Leaky Eligibility Trace Counter

This block keeps a short memory of recent learning events at one synapse. Each qualifying pre/post spike pair raises an 8-bit trace by one. A slow decay tick lowers it again at a programmable rate, so the trace fades toward zero when no new pairs arrive. A reward path elsewhere can read the trace and credit an update that happened some time before the reward came.

The trace runs only while its enable bit is set; otherwise it is forced to zero. The decay rate is a 4-bit field. An internal prescaler counts decay ticks, and the trace drops by one each time that count reaches the field value. A field value of zero turns decay off. A synchronous reset or the soft-clear control bit empties both the trace and the prescaler. The block only produces the trace value; it does not touch the weight-update outputs of the surrounding learning controller.

Top module: `elig_trace_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `trace_val` reads 0 after that edge.
- R2: With `trace_en`=1 and `soft_clr`=0, a one-cycle `pair_strobe` raises `trace_val` by exactly one, visible after the same clock edge.
- R3: The trace saturates at 255. A pair strobe at 255 leaves it at 255 and never wraps to 0.
- R4: While `trace_en`=0, `trace_val` is held at 0 and pair strobes and decay ticks are ignored. The prescaler is also emptied, so after re-enabling a full decay period of ticks is needed before the first drop.
- R5: With `decay_rate`=N (1..15), the trace drops by one on every N-th enabled `decay_tick` (ticks are counted whether or not the trace is zero) and stops at 0.
- R6: With `decay_rate`=0, decay ticks never lower the trace.
- R7: When a pair strobe and a due decay fall in the same cycle, the trace is raised by one and the decay is dropped. The prescaler still restarts its count from zero.
- R8: A one-cycle `soft_clr` clears both the trace and the prescaler. It has priority over a pair strobe in the same cycle, and after it a full N ticks are needed before the next drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Soft-reset control bit; clears trace and prescaler |
| trace_en | input | 1 | Trace enable control bit |
| pair_strobe | input | 1 | One-cycle strobe per qualifying spike pair |
| decay_tick | input | 1 | One-cycle decay time-base tick |
| decay_rate | input | 4 | Ticks per one-step decay; 0 disables decay |
| trace_val | output | 8 | Current trace value |

## Verification
The prescaler count is hidden, so the hardest cases are the ones where that count matters: it must be left part-way through a period when a soft clear, a disable, or a colliding pair strobe arrives. The bench puts it there by issuing N-1 ticks, then the disturbing event, then counts how many further ticks pass before the trace first drops. A stale count would show up as a drop that comes too early. Saturation is reached by driving a long run of pair strobes with decay turned off.

// File: rtl/elig_pkg.sv
package elig_pkg;

    // Action applied to the trace register in a cycle
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_INC  = 2'd1,
        ACT_DEC  = 2'd2,
        ACT_CLR  = 2'd3
    } trace_act_e;

    // Control inputs seen by the arbiter
    typedef struct packed {
        logic clear;
        logic enable;
        logic pair;
        logic decay_due;
        logic at_zero;
    } arb_in_t;

    function automatic trace_act_e pick_action(input arb_in_t a);
        if (a.clear || !a.enable)
            return ACT_CLR;
        else if (a.pair)
            return ACT_INC;
        else if (a.decay_due && !a.at_zero)
            return ACT_DEC;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/elig_decay_prescaler.sv
module elig_decay_prescaler #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic              due,
    output logic [RATE_W-1:0] count
);
    logic [RATE_W:0] count_nxt;
    logic            rate_zero;

    assign rate_zero = (rate == '0);
    assign count_nxt = {1'b0, count} + {{RATE_W{1'b0}}, 1'b1};
    assign due       = tick && !flush && !rate_zero && (count_nxt >= {1'b0, rate});

    always_ff @(posedge clk) begin
        if (rst || flush || rate_zero) begin
            count <= '0;
        end else if (tick) begin
            if (due)
                count <= '0;
            else
                count <= count_nxt[RATE_W-1:0];
        end
    end
endmodule

// File: rtl/elig_trace_reg.sv
module elig_trace_reg
    import elig_pkg::*;
#(
    parameter int TRACE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  trace_act_e         act,
    output logic [TRACE_W-1:0] value,
    output logic               at_zero
);
    localparam logic [TRACE_W-1:0] TMAX = '1;

    assign at_zero = (value == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else begin
            unique case (act)
                ACT_CLR:  value <= '0;
                ACT_INC:  if (value != TMAX) value <= value + 1'b1;
                ACT_DEC:  if (value != '0)   value <= value - 1'b1;
                default:  value <= value;
            endcase
        end
    end
endmodule

// File: rtl/elig_trace_unit.sv
module elig_trace_unit
    import elig_pkg::*;
#(
    parameter int TRACE_W = 8,
    parameter int RATE_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_clr,
    input  logic               trace_en,
    input  logic               pair_strobe,
    input  logic               decay_tick,
    input  logic [RATE_W-1:0]  decay_rate,
    output logic [TRACE_W-1:0] trace_val
);
    logic              flush;
    logic              decay_due;
    logic              at_zero;
    logic [RATE_W-1:0] presc_cnt;
    arb_in_t           arb_in;
    trace_act_e        act;

    assign flush = soft_clr || !trace_en;

    elig_decay_prescaler #(.RATE_W(RATE_W)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .tick  (decay_tick),
        .rate  (decay_rate),
        .due   (decay_due),
        .count (presc_cnt)
    );

    always_comb begin
        arb_in.clear     = soft_clr;
        arb_in.enable    = trace_en;
        arb_in.pair      = pair_strobe;
        arb_in.decay_due = decay_due;
        arb_in.at_zero   = at_zero;
        act              = pick_action(arb_in);
    end

    elig_trace_reg #(.TRACE_W(TRACE_W)) u_trace (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .value   (trace_val),
        .at_zero (at_zero)
    );
endmodule

// File: rtl/elig_trace_chk.sv
module elig_trace_chk #(
    parameter int TRACE_W = 8,
    parameter int RATE_W  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               soft_clr,
    input logic               trace_en,
    input logic               pair_strobe,
    input logic [RATE_W-1:0]  decay_rate,
    input logic [TRACE_W-1:0] trace_val,
    input logic [RATE_W-1:0]  presc_cnt
);
    localparam logic [TRACE_W-1:0] TMAX = '1;

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (trace_val == '0));

    p_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (trace_en && pair_strobe && !soft_clr && trace_val != TMAX)
        |=> (trace_val == TRACE_W'($past(trace_val) + 1'b1)));

    p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (trace_en && pair_strobe && !soft_clr && trace_val == TMAX)
        |=> (trace_val == TMAX));

    p_off_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !trace_en |=> (trace_val == '0 && presc_cnt == '0));

    p_unit_step_r5: assert property (@(posedge clk) disable iff (rst)
        (trace_en && !soft_clr && !pair_strobe)
        |=> (trace_val == $past(trace_val) ||
             trace_val == TRACE_W'($past(trace_val) - 1'b1)));

    p_no_decay_r6: assert property (@(posedge clk) disable iff (rst)
        (trace_en && !soft_clr && !pair_strobe && decay_rate == '0)
        |=> $stable(trace_val));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (trace_val == '0 && presc_cnt == '0));
endmodule

bind elig_trace_unit elig_trace_chk #(.TRACE_W(TRACE_W), .RATE_W(RATE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .soft_clr    (soft_clr),
    .trace_en    (trace_en),
    .pair_strobe (pair_strobe),
    .decay_rate  (decay_rate),
    .trace_val   (trace_val),
    .presc_cnt   (presc_cnt)
);

// File: tb/elig_trace_unit_tb_top.sv
module elig_trace_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_clr = 1'b0;
    logic       trace_en = 1'b0;
    logic       pair_strobe = 1'b0;
    logic       decay_tick = 1'b0;
    logic [3:0] decay_rate = 4'd0;
    logic [7:0] trace_val;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    elig_trace_unit dut_i (
        .clk         (clk),
        .rst         (rst),
        .soft_clr    (soft_clr),
        .trace_en    (trace_en),
        .pair_strobe (pair_strobe),
        .decay_tick  (decay_tick),
        .decay_rate  (decay_rate),
        .trace_val   (trace_val)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic step(input logic pair, input logic tick);
        @(negedge clk);
        pair_strobe = pair;
        decay_tick  = tick;
        @(posedge clk);
        #1;
        pair_strobe = 1'b0;
        decay_tick  = 1'b0;
    endtask

    task automatic check(input logic [7:0] exp, input string tag);
        n_vec++;
        if (trace_val !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d, expected %0d", tag, trace_val, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        soft_clr = 1'b1;
        @(posedge clk);
        #1;
        soft_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        trace_en = 1'b1;
        repeat (2) step(1'b1, 1'b0);
        check(8'd0, "R1 reset holds zero");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_inc_and_nodecay();
        decay_rate = 4'd0;
        do_clear();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        check(8'd5, "R2 five pairs");
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1);
        check(8'd5, "R6 rate zero no decay");
    endtask

    task automatic t_saturate();
        decay_rate = 4'd0;
        do_clear();
        for (int i = 0; i < 255; i++) step(1'b1, 1'b0);
        check(8'd255, "R3 reach max");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        check(8'd255, "R3 no wrap");
    endtask

    task automatic t_decay();
        decay_rate = 4'd3;
        do_clear();
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        check(8'd3, "R2 three pairs");
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check(8'd3, "R5 before third tick");
        step(1'b0, 1'b1);
        check(8'd2, "R5 drop on third tick");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
        check(8'd0, "R5 decayed to zero");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        check(8'd0, "R5 floor at zero");
    endtask

    task automatic t_collision();
        decay_rate = 4'd2;
        do_clear();
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        check(8'd2, "R5 one tick of two");
        step(1'b1, 1'b1);
        check(8'd3, "R7 increment wins");
        step(1'b0, 1'b1);
        check(8'd3, "R7 prescaler restarted");
        step(1'b0, 1'b1);
        check(8'd2, "R7 next drop after full period");
    endtask

    task automatic t_soft_clear();
        decay_rate = 4'd3;
        do_clear();
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        @(negedge clk);
        soft_clr = 1'b1;
        pair_strobe = 1'b1;
        @(posedge clk);
        #1;
        soft_clr = 1'b0;
        pair_strobe = 1'b0;
        check(8'd0, "R8 clear beats pair");
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check(8'd1, "R8 prescaler cleared");
        step(1'b0, 1'b1);
        check(8'd0, "R8 drop after full period");
    endtask

    task automatic t_disable();
        decay_rate = 4'd3;
        do_clear();
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        @(negedge clk);
        trace_en = 1'b0;
        step(1'b1, 1'b1);
        check(8'd0, "R4 disabled holds zero");
        step(1'b1, 1'b0);
        check(8'd0, "R4 pair ignored");
        @(negedge clk);
        trace_en = 1'b1;
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check(8'd1, "R4 prescaler emptied");
        step(1'b0, 1'b1);
        check(8'd0, "R4 drop after full period");
    endtask

    initial begin
        t_reset();
        t_inc_and_nodecay();
        t_saturate();
        t_decay();
        t_collision();
        t_soft_clear();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule